// File: doc/BRIEF.md
# Byte-Mapped GPIO Control Bank

This block gives software a byte-wide register window over a bank of general-purpose pins. Each access carries one address and one data byte, and reads are combinational from the current address. The lower part of the window returns eight read-only level bytes taken from an input vector. The middle part holds one control byte per pin. That byte carries an output-enable bit, a driven output value and a sampled input level. Every pin's enable and output value go to the pad logic as plain signals.

External logic reports pin input changes one at a time through an event port. Each event updates only the sampled input bit of the chosen pin. Two pins are wired to interrupt lines. One of them uses an active-low level sense and the other uses an active-high level sense. A non-maskable strobe input drives the active-high pin up and then down again, which gives a single one-cycle pulse on its interrupt line. If an input event reaches a pin that is currently configured as an output, a sticky error flag is raised.

Top module: `gpio_ctl_bank`

## Requirements
- R1: A read at offset k in 0..7 returns byte k of `lvl_i`, which is `lvl_i[8k+7:8k]` (byte 0 sits in the lowest bits).
- R2: Writes to offsets 0..7 and 44..47 change nothing. Reads at offsets 44..47 return 0x00.
- R3: A read at offset 8+p (p in 0..35) returns control byte p. Bit 2 of that byte is output enable, bit 1 is the sampled input and bit 0 is the output value. `pin_oe_o[p]` and `pin_out_o[p]` mirror bits 2 and 0.
- R4: A bus write of byte d to control byte p stores bits 7..2 and bit 0 of d. Bit 1 of d is never stored. When d[2] is 1, bit 1 becomes d[0]. When d[2] is 0, bit 1 keeps its previous value.
- R5: An input event (pin p, value v) sets bit 1 of byte p to v and leaves every other bit unchanged. An event whose value equals the stored bit 1 has no effect, and that includes no effect on the interrupts.
- R6: An input event on a pin whose bit 2 is 1 still performs the update, and it also sets `err_o`. `err_o` stays set until reset.
- R7: Pin 1 drives `irq_o[1]`. An input event that changes pin 1's bit 1 to 0 raises the line, and one that changes it to 1 lowers it.
- R8: Pin 9 drives `irq_o[9]`. An input event that changes pin 9's bit 1 to 1 raises the line, and one that changes it to 0 lowers it. Every other interrupt line stays 0.
- R9: A one-cycle `nmi_i` strobe first sets pin 9's input and then clears it on the following edge. The result is that `irq_o[9]` is 1 for exactly one cycle and pin 9's bit 1 ends at 0.
- R10: After reset, control byte 1 reads 0x02 and all other control bytes read 0x00. All interrupt lines are 0 and `err_o` is 0.
- R11: When a bus write and an input event target the same pin in the same cycle, the input event is applied after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 6 | Byte offset within the window |
| bus_wr_i | input | 1 | Write strobe for the current offset |
| bus_wdata_i | input | 8 | Write data byte |
| bus_rdata_o | output | 8 | Read data for the current offset (combinational) |
| lvl_i | input | 64 | Eight level bytes returned at offsets 0..7 |
| pin_ev_i | input | 1 | Input-event strobe |
| pin_idx_i | input | 6 | Pin addressed by the input event |
| pin_val_i | input | 1 | New input level for the event |
| nmi_i | input | 1 | Non-maskable strobe that pulses pin 9 |
| pin_oe_o | output | 36 | Per-pin output enable |
| pin_out_o | output | 36 | Per-pin output value |
| irq_o | output | 10 | Interrupt lines 0..9 |
| err_o | output | 1 | Sticky flag for an input event on an output pin |

## Verification
The assertions assume that every input is stable around the rising edge and that `pin_idx_i` names a pin that exists. The interrupt-polarity and write-loading properties skip any cycle in which a bus write or the NMI sequence also touches the same pin, because in those cycles the same-cycle ordering of R11 decides the result. The stimulus drives every input on the falling edge. It keeps NMI strobes away from bus writes and events on pin 9, and it tests same-cycle collisions only once, on a pin that has no interrupt line.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned BIT_OUT = 0;
    localparam int unsigned BIT_IN  = 1;
    localparam int unsigned BIT_OE  = 2;

    typedef enum logic [1:0] {
        REG_LEVEL,
        REG_CTRL,
        REG_NONE
    } region_e;

    // Bus write rule for a control byte: the written input bit is dropped;
    // with enable set the input bit follows the written output bit.
    function automatic logic [7:0] merge_write(logic [7:0] old_b, logic [7:0] wd);
        logic [7:0] nb;
        nb = wd;
        nb[BIT_IN] = wd[BIT_OE] ? wd[BIT_OUT] : old_b[BIT_IN];
        return nb;
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_LVL  = 8,
    parameter int unsigned NUM_PINS = 36,
    parameter int unsigned AW       = 6,
    parameter int unsigned IW       = 6
) (
    input  logic [AW-1:0] addr_i,
    output region_e       region_o,
    output logic [IW-1:0] index_o
);

    localparam int unsigned CTRL_END = NUM_LVL + NUM_PINS;

    always_comb begin
        region_o = REG_NONE;
        index_o  = '0;
        if (addr_i < AW'(NUM_LVL)) begin
            region_o = REG_LEVEL;
            index_o  = IW'(addr_i);
        end else if (addr_i < AW'(CTRL_END)) begin
            region_o = REG_CTRL;
            index_o  = IW'(addr_i - AW'(NUM_LVL));
        end
    end

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_LVL  = 8,
    parameter int unsigned NUM_PINS = 36,
    parameter int unsigned IW       = 6
) (
    input  region_e                   region_i,
    input  logic [IW-1:0]             index_i,
    input  logic [NUM_LVL*8-1:0]      lvl_i,
    input  logic [NUM_PINS*8-1:0]     ctrl_i,
    output logic [7:0]                rdata_o
);

    logic [7:0] lvl_sel;
    logic [7:0] ctrl_sel;

    always_comb begin
        lvl_sel  = '0;
        ctrl_sel = '0;
        for (int k = 0; k < NUM_LVL; k++) begin
            if (index_i == IW'(k)) lvl_sel = lvl_i[k*8 +: 8];
        end
        for (int k = 0; k < NUM_PINS; k++) begin
            if (index_i == IW'(k)) ctrl_sel = ctrl_i[k*8 +: 8];
        end
    end

    always_comb begin
        unique case (region_i)
            REG_LEVEL: rdata_o = lvl_sel;
            REG_CTRL:  rdata_o = ctrl_sel;
            default:   rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/gpio_ctl_bank.sv
module gpio_ctl_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_LVL   = 8,
    parameter int unsigned NUM_PINS  = 36,
    parameter int unsigned WIN_BYTES = 48,
    parameter int unsigned NUM_IRQ   = 10,
    parameter int unsigned LOW_PIN   = 1,
    parameter int unsigned HIGH_PIN  = 9,
    localparam int unsigned AW = $clog2(WIN_BYTES),
    localparam int unsigned IW = $clog2(NUM_PINS)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [AW-1:0]        bus_addr_i,
    input  logic                 bus_wr_i,
    input  logic [7:0]           bus_wdata_i,
    output logic [7:0]           bus_rdata_o,
    input  logic [NUM_LVL*8-1:0] lvl_i,
    input  logic                 pin_ev_i,
    input  logic [IW-1:0]        pin_idx_i,
    input  logic                 pin_val_i,
    input  logic                 nmi_i,
    output logic [NUM_PINS-1:0]  pin_oe_o,
    output logic [NUM_PINS-1:0]  pin_out_o,
    output logic [NUM_IRQ-1:0]   irq_o,
    output logic                 err_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0][7:0] ctrl;
        logic [NUM_IRQ-1:0]       irq;
        logic                     err;
        logic                     nmi_tail;
    } state_t;

    state_t st_d, st_q;

    region_e       region;
    logic [IW-1:0] index;

    // Sampled-input update; the interrupt of a wired pin moves only on a change.
    function automatic state_t set_input(state_t s, int unsigned k, logic v);
        logic [7:0] nb;
        nb = s.ctrl[k];
        nb[BIT_IN] = v;
        if (nb != s.ctrl[k]) begin
            s.ctrl[k] = nb;
            if (k == LOW_PIN)  s.irq[LOW_PIN]  = !v;
            if (k == HIGH_PIN) s.irq[HIGH_PIN] = v;
        end
        return s;
    endfunction

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        s = set_input(s, LOW_PIN, 1'b1);
        return s;
    endfunction

    gpio_addr_dec #(
        .NUM_LVL (NUM_LVL),
        .NUM_PINS(NUM_PINS),
        .AW      (AW),
        .IW      (IW)
    ) u_dec (
        .addr_i  (bus_addr_i),
        .region_o(region),
        .index_o (index)
    );

    gpio_rd_mux #(
        .NUM_LVL (NUM_LVL),
        .NUM_PINS(NUM_PINS),
        .IW      (IW)
    ) u_rd (
        .region_i(region),
        .index_i (index),
        .lvl_i   (lvl_i),
        .ctrl_i  (st_q.ctrl),
        .rdata_o (bus_rdata_o)
    );

    // Order within one cycle: bus write, input event, NMI tail, NMI head.
    always_comb begin
        st_d = st_q;
        if (bus_wr_i && region == REG_CTRL) begin
            for (int k = 0; k < NUM_PINS; k++) begin
                if (index == IW'(k)) st_d.ctrl[k] = merge_write(st_q.ctrl[k], bus_wdata_i);
            end
        end
        if (pin_ev_i) begin
            for (int k = 0; k < NUM_PINS; k++) begin
                if (pin_idx_i == IW'(k)) begin
                    if (st_d.ctrl[k][BIT_OE]) st_d.err = 1'b1;
                    st_d = set_input(st_d, k, pin_val_i);
                end
            end
        end
        if (st_q.nmi_tail) st_d = set_input(st_d, HIGH_PIN, 1'b0);
        if (nmi_i)         st_d = set_input(st_d, HIGH_PIN, 1'b1);
        st_d.nmi_tail = nmi_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= reset_state();
        else         st_q <= st_d;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
        assign pin_oe_o[p]  = st_q.ctrl[p][BIT_OE];
        assign pin_out_o[p] = st_q.ctrl[p][BIT_OUT];
    end

    assign irq_o = st_q.irq;
    assign err_o = st_q.err;

    logic [NUM_PINS*8-1:0] ctrl_flat;
    logic                  nmi_tail;
    assign ctrl_flat = st_q.ctrl;
    assign nmi_tail  = st_q.nmi_tail;

endmodule

// File: rtl/gpio_ctl_bank_chk.sv
module gpio_ctl_bank_chk #(
    parameter int unsigned NUM_LVL  = 8,
    parameter int unsigned NUM_PINS = 36,
    parameter int unsigned NUM_IRQ  = 10,
    parameter int unsigned LOW_PIN  = 1,
    parameter int unsigned HIGH_PIN = 9,
    parameter int unsigned AW       = 6,
    parameter int unsigned IW       = 6
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic [AW-1:0]         bus_addr_i,
    input logic                  bus_wr_i,
    input logic [7:0]            bus_wdata_i,
    input logic [7:0]            bus_rdata_o,
    input logic [NUM_LVL*8-1:0]  lvl_i,
    input logic                  pin_ev_i,
    input logic [IW-1:0]         pin_idx_i,
    input logic                  pin_val_i,
    input logic                  nmi_i,
    input logic [NUM_IRQ-1:0]    irq_o,
    input logic                  err_o,
    input logic [NUM_PINS*8-1:0] ctrl_flat,
    input logic                  nmi_tail
);

    localparam int unsigned CTRL_END = NUM_LVL + NUM_PINS;

    logic [7:0]    lvl_at, ctrl_at_addr, ctrl_at_pin, ctrl_at_wq;
    logic [IW-1:0] wr_idx, wr_idx_q;
    logic          in_ctrl;

    assign in_ctrl = (bus_addr_i >= AW'(NUM_LVL)) && (bus_addr_i < AW'(CTRL_END));
    assign wr_idx  = IW'(bus_addr_i - AW'(NUM_LVL));

    always_ff @(posedge clk_i) wr_idx_q <= wr_idx;

    always_comb begin
        lvl_at = '0; ctrl_at_addr = '0; ctrl_at_pin = '0; ctrl_at_wq = '0;
        for (int k = 0; k < NUM_LVL; k++)
            if (bus_addr_i == AW'(k)) lvl_at = lvl_i[k*8 +: 8];
        for (int k = 0; k < NUM_PINS; k++) begin
            if (wr_idx == IW'(k))    ctrl_at_addr = ctrl_flat[k*8 +: 8];
            if (pin_idx_i == IW'(k)) ctrl_at_pin  = ctrl_flat[k*8 +: 8];
            if (wr_idx_q == IW'(k))  ctrl_at_wq   = ctrl_flat[k*8 +: 8];
        end
    end

    logic wr_load, low_chg, high_chg, wr_hit9;
    assign wr_load  = bus_wr_i && in_ctrl && bus_wdata_i[2]
                      && !(pin_ev_i && pin_idx_i == wr_idx) && wr_idx != IW'(HIGH_PIN);
    assign low_chg  = pin_ev_i && pin_idx_i == IW'(LOW_PIN)
                      && !(bus_wr_i && bus_addr_i == AW'(NUM_LVL + LOW_PIN))
                      && ctrl_at_pin[1] != pin_val_i;
    assign high_chg = pin_ev_i && pin_idx_i == IW'(HIGH_PIN)
                      && !(bus_wr_i && bus_addr_i == AW'(NUM_LVL + HIGH_PIN))
                      && !nmi_i && !nmi_tail && ctrl_at_pin[1] != pin_val_i;
    assign wr_hit9  = bus_wr_i && bus_addr_i == AW'(NUM_LVL + HIGH_PIN);

    AST_LVL_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_addr_i < AW'(NUM_LVL) |-> bus_rdata_o == lvl_at); // R1
    AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_addr_i >= AW'(CTRL_END) |-> bus_rdata_o == 8'h00); // R2
    AST_CTRL_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_ctrl |-> bus_rdata_o == ctrl_at_addr); // R3
    AST_WRITE_LOADS_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_load |=> ctrl_at_wq[1] == $past(bus_wdata_i[0])); // R4
    AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pin_ev_i && pin_idx_i < IW'(NUM_PINS) && ctrl_at_pin[2] |=> err_o); // R6
    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o); // R6
    AST_LOW_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low_chg |=> irq_o[LOW_PIN] == !$past(pin_val_i)); // R7
    AST_HIGH_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        high_chg |=> irq_o[HIGH_PIN] == $past(pin_val_i)); // R8
    AST_NMI_PULSE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nmi_i ##1 (!nmi_i && !wr_hit9) |=> !irq_o[HIGH_PIN]); // R9

endmodule

bind gpio_ctl_bank gpio_ctl_bank_chk #(
    .NUM_LVL (NUM_LVL),
    .NUM_PINS(NUM_PINS),
    .NUM_IRQ (NUM_IRQ),
    .LOW_PIN (LOW_PIN),
    .HIGH_PIN(HIGH_PIN),
    .AW      (AW),
    .IW      (IW)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_addr_i (bus_addr_i),
    .bus_wr_i   (bus_wr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .lvl_i      (lvl_i),
    .pin_ev_i   (pin_ev_i),
    .pin_idx_i  (pin_idx_i),
    .pin_val_i  (pin_val_i),
    .nmi_i      (nmi_i),
    .irq_o      (irq_o),
    .err_o      (err_o),
    .ctrl_flat  (ctrl_flat),
    .nmi_tail   (nmi_tail)
);

// File: tb/gpio_ctl_bank_tb.sv
`timescale 1ns/1ps
module gpio_ctl_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [63:0] lvl = '0;
    logic        pin_ev = 1'b0;
    logic [5:0]  pin_idx = '0;
    logic        pin_val = 1'b0;
    logic        nmi = 1'b0;
    logic [35:0] pin_oe, pin_out;
    logic [9:0]  irq;
    logic        err;

    int n_checks = 0;
    int n_fail = 0;

    logic [7:0] m_ctrl [36];
    logic [9:0] m_irq;
    logic       m_err;

    always #2.5 clk = ~clk;

    gpio_ctl_bank u_dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .lvl_i(lvl),
        .pin_ev_i(pin_ev), .pin_idx_i(pin_idx), .pin_val_i(pin_val), .nmi_i(nmi),
        .pin_oe_o(pin_oe), .pin_out_o(pin_out), .irq_o(irq), .err_o(err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Model: set sampled input; interrupts move only on a change (R5, R7, R8).
    task automatic mdl_set(input int p, input logic v);
        logic [7:0] nb;
        nb = m_ctrl[p];
        nb[1] = v;
        if (nb != m_ctrl[p]) begin
            m_ctrl[p] = nb;
            if (p == 1) m_irq[1] = !v;
            if (p == 9) m_irq[9] = v;
        end
    endtask

    task automatic mdl_write(input int a, input logic [7:0] d);
        if (a >= 8 && a < 44)
            m_ctrl[a-8] = {d[7:2], (d[2] ? d[0] : m_ctrl[a-8][1]), d[0]};
    endtask

    task automatic bus_write(input int a, input logic [7:0] d);
        bus_addr = 6'(a); bus_wdata = d; bus_wr = 1'b1;
        mdl_write(a, d);
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic pin_event(input int p, input logic v);
        pin_idx = 6'(p); pin_val = v; pin_ev = 1'b1;
        if (m_ctrl[p][2]) m_err = 1'b1;
        mdl_set(p, v);
        tick();
        pin_ev = 1'b0;
    endtask

    task automatic check_rd(input string req, input int a, input logic [7:0] exp);
        bus_addr = 6'(a);
        #1;
        check(req, {56'd0, bus_rdata}, {56'd0, exp});
    endtask

    task automatic check_all(input string req);
        for (int a = 0; a < 48; a++) begin
            if (a < 8)       check_rd(req, a, lvl[a*8 +: 8]);
            else if (a < 44) check_rd(req, a, m_ctrl[a-8]);
            else             check_rd(req, a, 8'h00);
        end
    endtask

    task automatic check_pads(input string req);
        logic [35:0] eo, ev;
        for (int p = 0; p < 36; p++) begin
            eo[p] = m_ctrl[p][2];
            ev[p] = m_ctrl[p][0];
        end
        check(req, {28'd0, pin_oe}, {28'd0, eo});
        check(req, {28'd0, pin_out}, {28'd0, ev});
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int p = 0; p < 36; p++) m_ctrl[p] = 8'h00;
        m_ctrl[1] = 8'h02;
        m_irq = '0;
        m_err = 1'b0;
        @(negedge clk); tick(); tick();
        rst_n = 1'b1;

        // R10: reset defaults
        check_all("R10");
        check("R10 irq", {54'd0, irq}, 64'd0);
        check("R10 err", {63'd0, err}, 64'd0);

        // R1: level bytes, two patterns
        for (int k = 0; k < 8; k++) lvl[k*8 +: 8] = 8'(k * 37 + 11);
        for (int a = 0; a < 8; a++) check_rd("R1", a, 8'(a * 37 + 11));
        for (int k = 0; k < 8; k++) lvl[k*8 +: 8] = ~8'(k * 53);
        for (int a = 0; a < 8; a++) check_rd("R1", a, ~8'(a * 53));

        // R2: writes to level and unmapped offsets are ignored
        for (int a = 0; a < 8; a++) bus_write(a, 8'hFF);
        for (int a = 44; a < 48; a++) bus_write(a, 8'hFF);
        check_all("R2");

        // R4: every write byte on pin 0, read back
        for (int d = 0; d < 256; d++) begin
            bus_write(8, 8'(d));
            check_rd("R4", 8, m_ctrl[0]);
        end
        // R3/R4: all pins, enable off then on
        for (int p = 0; p < 36; p++) bus_write(8 + p, 8'((p * 41 + 7) & 8'hFB));
        check_all("R3");
        check_pads("R3");
        for (int p = 0; p < 36; p++) bus_write(8 + p, 8'((p * 23 + 1) | 8'h04));
        check_all("R4");
        check_pads("R3");
        check("R4 irq untouched", {54'd0, irq}, {54'd0, m_irq});

        // Clear all control bytes: input bit forced to 0 then enable dropped
        for (int p = 0; p < 36; p++) begin
            bus_write(8 + p, 8'h04);
            bus_write(8 + p, 8'h00);
        end
        check_all("R4");

        // R7: low-active pin
        pin_event(1, 1'b1);
        check("R7", {54'd0, irq}, {54'd0, m_irq});
        pin_event(1, 1'b0);
        check("R7 assert", {63'd0, irq[1]}, 64'd1);
        pin_event(1, 1'b0);
        check("R5 no change", {54'd0, irq}, {54'd0, m_irq});
        pin_event(1, 1'b1);
        check("R7 deassert", {63'd0, irq[1]}, 64'd0);

        // R8: high-active pin
        pin_event(9, 1'b1);
        check("R8 assert", {63'd0, irq[9]}, 64'd1);
        pin_event(9, 1'b0);
        check("R8 deassert", {63'd0, irq[9]}, 64'd0);

        // R5: event on an ordinary pin touches only its input bit
        pin_event(5, 1'b1);
        check_all("R5");
        check("R5 irq", {54'd0, irq}, {54'd0, m_irq});
        check("R5 err", {63'd0, err}, 64'd0);

        // R9: NMI pulse
        nmi = 1'b1;
        mdl_set(9, 1'b1);
        tick();
        nmi = 1'b0;
        check("R9 pulse", {63'd0, irq[9]}, 64'd1);
        mdl_set(9, 1'b0);
        tick();
        check("R9 end", {63'd0, irq[9]}, 64'd0);
        check_rd("R9 pin bit", 17, m_ctrl[9]);
        tick();
        check("R9 single", {63'd0, irq[9]}, 64'd0);

        // R6: event on an output pin, update still done, flag sticky
        bus_write(11, 8'h04);
        pin_event(3, 1'b1);
        check("R6 set", {63'd0, err}, 64'd1);
        check_rd("R6 update", 11, 8'h06);
        pin_event(4, 1'b1);
        tick();
        check("R6 sticky", {63'd0, err}, 64'd1);

        // R11: same-cycle write and event on pin 7
        bus_addr = 6'd15; bus_wdata = 8'h05; bus_wr = 1'b1;
        pin_idx = 6'd7; pin_val = 1'b0; pin_ev = 1'b1;
        mdl_write(15, 8'h05);
        m_err = 1'b1;
        mdl_set(7, 1'b0);
        tick();
        bus_wr = 1'b0; pin_ev = 1'b0;
        check_rd("R11", 15, 8'h05);
        check_all("R11");

        finish_run();
    end

endmodule